// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block tracks two kinds of pending interrupt for a small group of up to four processors: software-raised inter-processor interrupts (IPIs) and interval-timer interrupts. Each kind is held as a vector with one bit per processor. Each bit drives a level output to its processor. Software posts and clears these interrupts over a 64-bit register port. It can use one combined control register whose fields carry several per-processor masks at once, or three dedicated registers that each take a single mask in their low bits. A timer tick input marks the timer interrupt pending on every processor that is present.

A reading processor puts its 2-bit identity on the port with the read strobe, and the combined register returns that identity beside both pending vectors. A processor-count input limits which mask bits take effect. Mask bits for processors at or above that count are dropped. Posting an IPI that is already pending, or clearing an interrupt that is idle, changes no state. A write that names no operation at all, or a dedicated write with an empty mask, is flagged as an error.

Top module: `ipi_tmr_ctl`

## Requirements
- R1: While reset is asserted and until the first operation after its release, both pending vectors, `ipi_irq`, `tmr_irq`, `op_err`, `op_warn` and `rdata` are all zero.
- R2: A write with `sel`=0 (combined register) uses three masks. Bits [15:12] post IPIs, bits [11:8] clear IPIs and bits [7:4] clear timer interrupts. When one write both posts and clears the IPI of the same processor, the clear wins. The new state appears on the outputs at the first clock edge after the write.
- R3: Register selects 1, 2 and 3 act on the mask in `wdata[3:0]`. `sel`=1 posts IPIs, `sel`=2 clears IPIs and `sel`=3 clears timer interrupts. All other bits of `wdata` are ignored.
- R4: Posting an IPI to a present processor whose IPI is already pending leaves the state unchanged and pulses `op_warn` for one cycle after the write.
- R5: Clearing an IPI or a timer interrupt that is not pending leaves the state unchanged and raises neither `op_err` nor `op_warn`.
- R6: A cycle with `tick` high sets the timer-pending bit of every present processor. If the same cycle also clears a timer bit, the tick wins and the bit ends set.
- R7: A combined-register write is an error, and pulses `op_err` one cycle later, when bits [15:4] and bit 28 are all zero. A write with only bit 28 set is accepted, changes no state and raises no error. Bits 27:16 and 3:0 never qualify a write as supported.
- R8: A dedicated-register write with `wdata[3:0]`=0 pulses `op_err` one cycle later and changes no state. `op_err` is low after any cycle with no write.
- R9: The effective processor count is `cpu_count` with 0 read as 1 and values above 4 read as 4. Mask bits and tick effects for processor numbers at or above that count are ignored.
- R10: With `rd_en` high, `rdata` is loaded at the next clock edge with the state from before any write in the same cycle. `sel`=0 returns `rd_cpu` in [1:0], the timer vector in [7:4] and the IPI vector in [11:8]. `sel`=1 returns zero. `sel`=2 returns the IPI vector and `sel`=3 the timer vector, each in [3:0]. All other bits read as zero, and `rdata` holds while `rd_en` is low.
- R11: `ipi_irq` and `tmr_irq` equal the pending vectors bit for bit, and stay unchanged in any cycle with neither a write nor a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_count | input | 3 | Number of present processors (clamped to 1..4) |
| tick | input | 1 | Interval timer tick, one cycle per event |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| sel | input | 2 | Register select: 0 combined, 1 IPI post, 2 IPI pending, 3 timer pending |
| wdata | input | 64 | Write data |
| rd_cpu | input | 2 | Identity of the reading processor |
| rdata | output | 64 | Registered read data |
| ipi_irq | output | 4 | Per-processor IPI level |
| tmr_irq | output | 4 | Per-processor timer interrupt level |
| op_err | output | 1 | One-cycle pulse: unsupported write or empty mask |
| op_warn | output | 1 | One-cycle pulse: IPI posted to a processor already pending |

## Verification
The hardest states to reach are the collisions: a combined write that posts and clears the same IPI, and a tick that coincides with a timer clear. Each must also happen while part of the masks falls on processors that are absent. The bench reaches them by sweeping all 4096 values of the three combined-register masks, together with the tick, for each processor count from one to four. The state built up by earlier vectors keeps changing, so each mask pattern meets many different pending vectors. Every step also reads back the register from the cycle before, so read-before-write ordering is checked on every collision.

// File: rtl/ipi_tmr_pkg.sv
package ipi_tmr_pkg;

  localparam int unsigned MAX_CPU  = 4;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned CNT_W    = 3;
  localparam int unsigned ID_W     = 2;

  // field positions in the combined register (software decodes these)
  localparam int unsigned TMR_FLD_LSB = 4;
  localparam int unsigned IPI_FLD_LSB = 8;
  localparam int unsigned REQ_FLD_LSB = 12;
  localparam int unsigned ACK_BIT     = 28;

  typedef enum logic [1:0] {
    SEL_COMBO    = 2'd0,
    SEL_IPI_POST = 2'd1,
    SEL_IPI_PEND = 2'd2,
    SEL_TMR_PEND = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/ipi_tmr_present.sv
module ipi_tmr_present
  import ipi_tmr_pkg::*;
#(
  parameter int unsigned NCPU = 4
) (
  input  logic [CNT_W-1:0]   cpu_count,
  output logic [MAX_CPU-1:0] present
);

  logic [CNT_W-1:0] eff_cnt;

  always_comb begin
    if (cpu_count == '0)
      eff_cnt = CNT_W'(1);
    else if (cpu_count > CNT_W'(NCPU))
      eff_cnt = CNT_W'(NCPU);
    else
      eff_cnt = cpu_count;
  end

  for (genvar i = 0; i < MAX_CPU; i++) begin : g_pres
    if (i < NCPU) begin : g_live
      assign present[i] = (eff_cnt > CNT_W'(i));
    end else begin : g_dead
      assign present[i] = 1'b0;
    end
  end

endmodule

// File: rtl/ipi_tmr_decode.sv
module ipi_tmr_decode
  import ipi_tmr_pkg::*;
(
  input  logic               wr_en,
  input  logic [1:0]         sel,
  input  logic [MAX_CPU-1:0] fld_req,
  input  logic [MAX_CPU-1:0] fld_iclr,
  input  logic [MAX_CPU-1:0] fld_tclr,
  input  logic               fld_ack,
  input  logic [MAX_CPU-1:0] dmask,
  input  logic               tick,
  input  logic [MAX_CPU-1:0] present,
  input  logic [MAX_CPU-1:0] ipi_q,
  output logic [MAX_CPU-1:0] ipi_set,
  output logic [MAX_CPU-1:0] ipi_clr,
  output logic [MAX_CPU-1:0] tmr_set,
  output logic [MAX_CPU-1:0] tmr_clr,
  output logic               err_d,
  output logic               warn_d
);

  reg_sel_e sel_e;
  assign sel_e = reg_sel_e'(sel);

  always_comb begin
    ipi_set = '0;
    ipi_clr = '0;
    tmr_clr = '0;
    err_d   = 1'b0;
    if (wr_en) begin
      unique case (sel_e)
        SEL_COMBO: begin
          ipi_set = fld_req  & present;
          ipi_clr = fld_iclr & present;
          tmr_clr = fld_tclr & present;
          err_d   = ~((|fld_req) | (|fld_iclr) | (|fld_tclr) | fld_ack);
        end
        SEL_IPI_POST: begin
          ipi_set = dmask & present;
          err_d   = ~(|dmask);
        end
        SEL_IPI_PEND: begin
          ipi_clr = dmask & present;
          err_d   = ~(|dmask);
        end
        SEL_TMR_PEND: begin
          tmr_clr = dmask & present;
          err_d   = ~(|dmask);
        end
        default: ;
      endcase
    end
    tmr_set = tick ? present : '0;
    warn_d  = |(ipi_set & ipi_q);
  end

endmodule

// File: rtl/ipi_tmr_pend.sv
module ipi_tmr_pend #(
  parameter int unsigned W        = 4,
  parameter bit          SET_WINS = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_d;
  logic         en;

  if (SET_WINS) begin : g_set_wins
    always_comb q_d = (q_r & ~clr) | set;
  end else begin : g_clr_wins
    always_comb q_d = (q_r | set) & ~clr;
  end

  assign en = |(set | clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q_r <= '0;
    else if (en)
      q_r <= q_d;
  end

  assign q = q_r;

endmodule

// File: rtl/ipi_tmr_rdreg.sv
module ipi_tmr_rdreg
  import ipi_tmr_pkg::*;
#(
  parameter int unsigned NCPU = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [1:0]        sel,
  input  logic [ID_W-1:0]   rd_cpu,
  input  logic [NCPU-1:0]   ipi_q,
  input  logic [NCPU-1:0]   tmr_q,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rd_r;
  reg_sel_e          sel_e;

  assign sel_e = reg_sel_e'(sel);

  always_comb begin
    rd_d = '0;
    unique case (sel_e)
      SEL_COMBO: begin
        rd_d[ID_W-1:0]               = rd_cpu;
        rd_d[TMR_FLD_LSB +: NCPU]    = tmr_q;
        rd_d[IPI_FLD_LSB +: NCPU]    = ipi_q;
      end
      SEL_IPI_POST: rd_d = '0;
      SEL_IPI_PEND: rd_d[NCPU-1:0] = ipi_q;
      SEL_TMR_PEND: rd_d[NCPU-1:0] = tmr_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_r <= '0;
    else if (rd_en)
      rd_r <= rd_d;
  end

  assign rdata = rd_r;

endmodule

// File: rtl/ipi_tmr_ctl.sv
module ipi_tmr_ctl
  import ipi_tmr_pkg::*;
#(
  parameter int unsigned NCPU = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cpu_count,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        sel,
  input  logic [63:0]       wdata,
  input  logic [1:0]        rd_cpu,
  output logic [63:0]       rdata,
  output logic [3:0]        ipi_irq,
  output logic [3:0]        tmr_irq,
  output logic              op_err,
  output logic              op_warn
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= '0;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [MAX_CPU-1:0] present;
  logic [MAX_CPU-1:0] ipi_set, ipi_clr, tmr_set, tmr_clr;
  logic [NCPU-1:0]    ipi_q, tmr_q;
  logic [MAX_CPU-1:0] ipi_q_ext;
  logic               err_d, warn_d;
  logic               err_r, warn_r;

  assign ipi_q_ext = MAX_CPU'(ipi_q);

  ipi_tmr_present #(.NCPU(NCPU)) u_present (
    .cpu_count (cpu_count),
    .present   (present)
  );

  ipi_tmr_decode u_decode (
    .wr_en    (wr_en),
    .sel      (sel),
    .fld_req  (wdata[REQ_FLD_LSB +: MAX_CPU]),
    .fld_iclr (wdata[IPI_FLD_LSB +: MAX_CPU]),
    .fld_tclr (wdata[TMR_FLD_LSB +: MAX_CPU]),
    .fld_ack  (wdata[ACK_BIT]),
    .dmask    (wdata[MAX_CPU-1:0]),
    .tick     (tick),
    .present  (present),
    .ipi_q    (ipi_q_ext),
    .ipi_set  (ipi_set),
    .ipi_clr  (ipi_clr),
    .tmr_set  (tmr_set),
    .tmr_clr  (tmr_clr),
    .err_d    (err_d),
    .warn_d   (warn_d)
  );

  // IPI: a clear in the same write overrides a post
  ipi_tmr_pend #(.W(NCPU), .SET_WINS(1'b0)) u_ipi (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set   (ipi_set[NCPU-1:0]),
    .clr   (ipi_clr[NCPU-1:0]),
    .q     (ipi_q)
  );

  // timer: a tick overrides a clear in the same cycle
  ipi_tmr_pend #(.W(NCPU), .SET_WINS(1'b1)) u_tmr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set   (tmr_set[NCPU-1:0]),
    .clr   (tmr_clr[NCPU-1:0]),
    .q     (tmr_q)
  );

  ipi_tmr_rdreg #(.NCPU(NCPU)) u_rd (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .rd_en  (rd_en),
    .sel    (sel),
    .rd_cpu (rd_cpu),
    .ipi_q  (ipi_q),
    .tmr_q  (tmr_q),
    .rdata  (rdata)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_r  <= 1'b0;
      warn_r <= 1'b0;
    end else begin
      err_r  <= err_d;
      warn_r <= warn_d;
    end
  end

  assign ipi_irq = MAX_CPU'(ipi_q);
  assign tmr_irq = MAX_CPU'(tmr_q);
  assign op_err  = err_r;
  assign op_warn = warn_r;

endmodule

// File: rtl/ipi_tmr_ctl_chk.sv
module ipi_tmr_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        tick,
  input logic [1:0]  sel,
  input logic [63:0] wdata,
  input logic [3:0]  ipi_irq,
  input logic [3:0]  tmr_irq,
  input logic        op_err,
  input logic        op_warn
);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !tick) |=> ($stable(ipi_irq) && $stable(tmr_irq)));

  assert_tick_cpu0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> tmr_irq[0]);

  assert_unsupported_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd0 && wdata[15:4] == 12'd0 && !wdata[28]) |=> op_err);

  assert_quiet_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !op_err);

  assert_post_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd1 && wdata[0]) |=> ipi_irq[0]);

  assert_clear_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd0 && wdata[8]) |=> !ipi_irq[0]);

  assert_dup_warn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd1 && wdata[0] && ipi_irq[0]) |=> op_warn);

endmodule

bind ipi_tmr_ctl ipi_tmr_ctl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .wr_en   (wr_en),
  .tick    (tick),
  .sel     (sel),
  .wdata   (wdata),
  .ipi_irq (ipi_irq),
  .tmr_irq (tmr_irq),
  .op_err  (op_err),
  .op_warn (op_warn)
);

// File: tb/ipi_tmr_ctl_bench.sv
`timescale 1ns/1ps
module ipi_tmr_ctl_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cpu_count;
  logic        tick, wr_en, rd_en;
  logic [1:0]  sel, rd_cpu;
  logic [63:0] wdata;
  logic [63:0] rdata;
  logic [3:0]  ipi_irq, tmr_irq;
  logic        op_err, op_warn;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // bench model state
  logic [3:0]  m_ipi, m_tmr;
  logic [63:0] m_rd;

  always #4 clk = ~clk;

  ipi_tmr_ctl u_ipi_tmr_ctl (
    .clk(clk), .rst_n(rst_n), .cpu_count(cpu_count), .tick(tick),
    .wr_en(wr_en), .rd_en(rd_en), .sel(sel), .wdata(wdata), .rd_cpu(rd_cpu),
    .rdata(rdata), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
    .op_err(op_err), .op_warn(op_warn)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] pmask(input logic [2:0] c);
    int e;
    e = (c == 0) ? 1 : ((c > 4) ? 4 : int'(c));
    return 4'((1 << e) - 1);
  endfunction

  // one cycle: drive at negedge, check at the following negedge
  task automatic step(input logic w, input logic [1:0] s, input logic [63:0] d,
                      input logic t, input logic r, input logic [1:0] rc,
                      input string tag);
    logic [3:0] p, rq, ic, tc;
    logic       e_err, e_warn;
    p = pmask(cpu_count);
    if (r) begin
      m_rd = '0;
      case (s)
        2'd0: begin m_rd[1:0] = rc; m_rd[7:4] = m_tmr; m_rd[11:8] = m_ipi; end
        2'd2: m_rd[3:0] = m_ipi;
        2'd3: m_rd[3:0] = m_tmr;
        default: m_rd = '0;
      endcase
    end
    rq = '0; ic = '0; tc = '0; e_err = 1'b0;
    if (w) begin
      case (s)
        2'd0: begin
          rq = d[15:12] & p; ic = d[11:8] & p; tc = d[7:4] & p;
          e_err = (d[15:4] == 12'd0) && !d[28];
        end
        2'd1: begin rq = d[3:0] & p; e_err = (d[3:0] == 4'd0); end
        2'd2: begin ic = d[3:0] & p; e_err = (d[3:0] == 4'd0); end
        default: begin tc = d[3:0] & p; e_err = (d[3:0] == 4'd0); end
      endcase
    end
    e_warn = |(rq & m_ipi);
    m_ipi = (m_ipi | rq) & ~ic;
    m_tmr = (m_tmr & ~tc) | (t ? p : 4'd0);
    wr_en = w; sel = s; wdata = d; tick = t; rd_en = r; rd_cpu = rc;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; rd_en = 1'b0;
    chk({tag, " ipi_irq"}, 64'(ipi_irq), 64'(m_ipi));
    chk({tag, " tmr_irq"}, 64'(tmr_irq), 64'(m_tmr));
    chk({tag, " op_err"},  64'(op_err),  64'(e_err));
    chk({tag, " op_warn"}, 64'(op_warn), 64'(e_warn));
    chk({tag, " rdata"},   rdata,        m_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_count = 3'd4; tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    sel = 2'd0; wdata = '0; rd_cpu = 2'd0;
    m_ipi = '0; m_tmr = '0; m_rd = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ipi_irq", 64'(ipi_irq), 64'd0);
    chk("R1 tmr_irq", 64'(tmr_irq), 64'd0);
    chk("R1 op_err",  64'(op_err),  64'd0);
    chk("R1 op_warn", 64'(op_warn), 64'd0);
    chk("R1 rdata",   rdata,        64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", 64'({ipi_irq, tmr_irq}), 64'd0);

    // R3, R8: dedicated registers over every mask
    for (int m = 0; m < 16; m++) begin
      step(1'b1, 2'd1, 64'hFFFF_0000_0000_0000 | 64'(m), 1'b0, 1'b0, 2'd0, "R3 post");
      step(1'b0, 2'd2, 64'd0, 1'b1, 1'b1, 2'd0, "R10 read ipi");
      step(1'b1, 2'd2, 64'(m), 1'b0, 1'b1, 2'd0, "R3 clear ipi");
      step(1'b1, 2'd3, 64'(15 - m), 1'b0, 1'b1, 2'd3, "R3 clear tmr");
      step(1'b1, 2'd1, 64'(m), 1'b0, 1'b0, 2'd0, "R8 empty-mask");
    end

    // R4: duplicate post
    step(1'b1, 2'd2, 64'hF, 1'b0, 1'b0, 2'd0, "R4 setup");
    step(1'b1, 2'd1, 64'h2, 1'b0, 1'b0, 2'd0, "R4 first post");
    step(1'b1, 2'd1, 64'h2, 1'b0, 1'b0, 2'd0, "R4 duplicate post");
    step(1'b1, 2'd0, 64'h0000_2000, 1'b0, 1'b0, 2'd0, "R4 duplicate via combo");

    // R5: clearing idle interrupts
    step(1'b1, 2'd2, 64'hF, 1'b0, 1'b0, 2'd0, "R5 clear");
    step(1'b1, 2'd2, 64'hF, 1'b0, 1'b0, 2'd0, "R5 clear idle ipi");
    step(1'b1, 2'd3, 64'hF, 1'b0, 1'b0, 2'd0, "R5 clear tmr");
    step(1'b1, 2'd3, 64'hF, 1'b0, 1'b0, 2'd0, "R5 clear idle tmr");
    step(1'b1, 2'd0, 64'h0000_0FF0, 1'b0, 1'b0, 2'd0, "R5 idle combo clear");

    // R7: acknowledge bit and unsupported writes
    step(1'b1, 2'd0, 64'h1000_0000, 1'b0, 1'b0, 2'd0, "R7 ack only");
    step(1'b1, 2'd0, 64'h0000_0000, 1'b0, 1'b0, 2'd0, "R7 empty");
    step(1'b1, 2'd0, 64'hEFFF_000F, 1'b0, 1'b0, 2'd0, "R7 unrelated bits");

    // R9: clamp of processor count
    for (int c = 0; c < 8; c++) begin
      cpu_count = 3'(c);
      step(1'b1, 2'd1, 64'hF, 1'b1, 1'b0, 2'd0, "R9 post and tick");
      step(1'b0, 2'd0, 64'd0, 1'b0, 1'b1, 2'(c), "R9 read");
      step(1'b1, 2'd0, 64'h0000_0FF0, 1'b0, 1'b0, 2'd0, "R9 clear");
    end

    // R11, R10: idle cycles hold state and read data
    step(1'b1, 2'd1, 64'h5, 1'b1, 1'b1, 2'd1, "R11 load");
    for (int i = 0; i < 4; i++)
      step(1'b0, 2'(i), 64'hFFFF, 1'b0, 1'b0, 2'd2, "R11 idle");

    // R2, R6: sweep of all combined-register masks with tick, per processor count
    for (int c = 1; c <= 4; c++) begin
      cpu_count = 3'(c);
      for (int k = 0; k < 8192; k++)
        step(1'b1, 2'd0, 64'({k[11:0], 4'b0}), k[12], 1'b1, 2'(k), "R2 R6 sweep");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule